// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Outcome History

This block sits beside the fetch address register and guesses where fetch goes next. It keeps a small, fully associative set of entries. Each entry records the address of a branch that has executed before, the two most recent actual outcomes of that branch, and the last target address the branch produced. In every cycle the present fetch address is compared with all valid entries at once. When one matches, the block reports a hit, a predicted direction taken from that entry's outcome record, and a speculative next fetch address. That address is the stored target when the prediction is taken. In every other case it is the fetch address plus the instruction step.

When a branch resolves in the execute stage, an update port delivers its address, its real direction and its real target. An entry that already holds that branch shifts the new outcome into its history and keeps the new target. A branch with no entry gets one: the lowest-numbered free slot if there is one, and otherwise the slot named by a round-robin pointer, which always points at the oldest fill. A new entry starts with both history bits equal to the single resolved outcome. A lookup in the same cycle as an update sees the contents from before that update.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset invalidates every entry and returns the replacement pointer to entry 0. After reset every lookup misses: hit=0, pred_taken=0, and next_fetch_addr equals fetch_addr+PC_STEP.
- R2: hit is 1 exactly when some valid entry holds a branch address equal to fetch_addr. At most one entry matches at a time.
- R3: On a hit, pred_taken equals the newest recorded outcome of the matching entry (1 = taken). The older outcome does not affect the prediction.
- R4: next_fetch_addr equals the matching entry's stored target when hit=1 and pred_taken=1. Otherwise it equals fetch_addr+PC_STEP.
- R5: An update (upd_valid=1) whose upd_addr matches a valid entry makes upd_taken that entry's newest outcome. The previous newest outcome becomes the older one, and upd_target replaces the stored target. The change is visible from the next cycle.
- R6: An update that matches no entry fills the lowest-indexed invalid entry with upd_addr and upd_target, with both history bits set to upd_taken.
- R7: When all entries are valid, a missing update replaces the entry at the round-robin pointer, which then advances by one and wraps after ENTRIES-1. Starting from reset, this evicts entries in the order they were filled.
- R8: A lookup in the same cycle as an update to the same address returns the contents from before the update.
- R9: While upd_valid=0, the upd_addr, upd_taken and upd_target inputs have no effect on any entry.
- R10: pred_taken is 0 whenever hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | input | ADDR_W | Current fetch address |
| hit | output | 1 | A valid entry matches fetch_addr |
| pred_taken | output | 1 | Predicted direction of the matched branch |
| next_fetch_addr | output | ADDR_W | Speculative next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction, 1 = taken |
| upd_target | input | ADDR_W | Actual target address |

## Verification
The bench builds the block with ENTRIES=4, ADDR_W=32 and PC_STEP=4. With only four entries and random traffic drawn from a pool of ten branch addresses, the buffer fills often, and the round-robin pointer wraps many times. Evicted branches come back and are allocated again. The random traffic also often places an update and a lookup on the same address in one cycle. Directed steps fix the allocation order after reset, the shifting of the history on repeated updates, and the eviction of the first-filled entry.

// File: rtl/btb_pkg.sv
package btb_pkg;
   // history layout: bit 0 = newest outcome, bit 1 = older outcome
   localparam int HIST_W = 2;
   typedef logic [HIST_W-1:0] hist_t;

   function automatic logic hist_predict(input hist_t h);
      return h[0];
   endfunction

   function automatic hist_t hist_shift(input hist_t h, input logic taken);
      return {h[0], taken};
   endfunction

   function automatic hist_t hist_seed(input logic taken);
      return {taken, taken};
   endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [ADDR_W-1:0]  tags [ENTRIES],
   input  logic [ADDR_W-1:0]  key,
   output logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = valid[e] && (tags[e] == key);
   end

   always_comb begin
      idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) idx = IDX_W'(e);
      end
   end

   assign any = |match;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] valid,
   input  logic               alloc,
   output logic [IDX_W-1:0]   victim,
   output logic [IDX_W-1:0]   rr_ptr
);
   logic             have_free;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid[e]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(e);
         end
      end
   end

   assign victim = have_free ? free_idx : rr_ptr;

   always_ff @(posedge clk) begin
      if (rst) begin
         rr_ptr <= '0;
      end else if (alloc && !have_free) begin
         rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   parameter int PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              hit,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] next_fetch_addr,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target
);
   import btb_pkg::*;

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_width
      $error("btb_predictor: ADDR_W must be at least 8");
   end
   if (PC_STEP < 1) begin : g_bad_step
      $error("btb_predictor: PC_STEP must be positive");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [ADDR_W-1:0]  tag_q    [ENTRIES];
   logic [ADDR_W-1:0]  target_q [ENTRIES];
   hist_t              hist_q   [ENTRIES];

   logic [ENTRIES-1:0] fetch_match, upd_match;
   logic               fetch_any, upd_any;
   logic [IDX_W-1:0]   fetch_idx, upd_idx, victim_idx, rr_ptr;
   logic               alloc;

   btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fetch_cmp (
      .valid(valid_q), .tags(tag_q), .key(fetch_addr),
      .match(fetch_match), .any(fetch_any), .idx(fetch_idx)
   );

   btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_upd_cmp (
      .valid(valid_q), .tags(tag_q), .key(upd_addr),
      .match(upd_match), .any(upd_any), .idx(upd_idx)
   );

   assign alloc = upd_valid && !upd_any;

   btb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst(rst), .valid(valid_q), .alloc(alloc),
      .victim(victim_idx), .rr_ptr(rr_ptr)
   );

   // lookup reads registered state only: same-cycle updates stay invisible
   assign hit             = fetch_any;
   assign pred_taken      = fetch_any && hist_predict(hist_q[fetch_idx]);
   assign next_fetch_addr = pred_taken ? target_q[fetch_idx]
                                       : fetch_addr + ADDR_W'(PC_STEP);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else if (upd_valid) begin
         if (upd_any) begin
            hist_q[upd_idx]   <= hist_shift(hist_q[upd_idx], upd_taken);
            target_q[upd_idx] <= upd_target;
         end else begin
            valid_q[victim_idx]  <= 1'b1;
            tag_q[victim_idx]    <= upd_addr;
            target_q[victim_idx] <= upd_target;
            hist_q[victim_idx]   <= hist_seed(upd_taken);
         end
      end
   end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   parameter int PC_STEP = 4
) (
   input logic               clk,
   input logic               rst,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic               hit,
   input logic               pred_taken,
   input logic [ADDR_W-1:0]  next_fetch_addr,
   input logic               upd_valid,
   input logic [ADDR_W-1:0]  upd_addr,
   input logic               upd_taken,
   input logic [ADDR_W-1:0]  upd_target,
   input logic [ENTRIES-1:0] fetch_match
);
   assert_reset_miss_R1: assert property (@(posedge clk)
      rst |=> !hit);

   assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fetch_match));

   assert_seq_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
      !hit |-> next_fetch_addr == fetch_addr + ADDR_W'(PC_STEP));

   assert_update_dir_R5: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && !rst) ##1 (fetch_addr == $past(upd_addr))
      |-> hit && (pred_taken == $past(upd_taken)));

   assert_update_target_R4: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && upd_taken && !rst) ##1 (fetch_addr == $past(upd_addr))
      |-> next_fetch_addr == $past(upd_target));

   assert_no_pred_on_miss_R10: assert property (@(posedge clk) disable iff (rst)
      pred_taken |-> hit);
endmodule

bind btb_predictor btb_checker #(
   .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PC_STEP(PC_STEP)
) u_chk (
   .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .hit(hit),
   .pred_taken(pred_taken), .next_fetch_addr(next_fetch_addr),
   .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
   .upd_target(upd_target), .fetch_match(fetch_match)
);

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 4;
   localparam int AW = 32;
   localparam int STEP = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] fetch_addr = '0;
   logic          hit, pred_taken;
   logic [AW-1:0] next_fetch_addr;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_addr = '0;
   logic          upd_taken = 1'b0;
   logic [AW-1:0] upd_target = '0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   btb_predictor #(.ENTRIES(NE), .ADDR_W(AW), .PC_STEP(STEP)) u0 (
      .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .hit(hit),
      .pred_taken(pred_taken), .next_fetch_addr(next_fetch_addr),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
      .upd_target(upd_target)
   );

   // reference state built from the requirements
   logic          m_valid [NE];
   logic [AW-1:0] m_addr  [NE];
   logic [AW-1:0] m_tgt   [NE];
   logic          m_new   [NE];
   logic          m_old   [NE];
   int            m_rr;

   function automatic int m_find(input logic [AW-1:0] a);
      for (int e = 0; e < NE; e++) if (m_valid[e] && m_addr[e] == a) return e;
      return -1;
   endfunction

   function automatic int m_victim();
      for (int e = 0; e < NE; e++) if (!m_valid[e]) return e;
      return -1;
   endfunction

   task automatic check(input logic ok, input string tag,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      for (int e = 0; e < NE; e++) m_valid[e] = 1'b0;
      m_rr = 0;
   endtask

   task automatic m_update();
      int i;
      i = m_find(upd_addr);
      if (i >= 0) begin
         m_old[i] = m_new[i];
         m_new[i] = upd_taken;
         m_tgt[i] = upd_target;
      end else begin
         i = m_victim();
         if (i < 0) begin
            i = m_rr;
            m_rr = (m_rr + 1) % NE;
         end
         m_valid[i] = 1'b1;
         m_addr[i]  = upd_addr;
         m_tgt[i]   = upd_target;
         m_new[i]   = upd_taken;
         m_old[i]   = upd_taken;
      end
   endtask

   // one cycle: drive at negedge, compare before posedge, then advance the model
   task automatic step(input logic [AW-1:0] fa, input logic uv,
                       input logic [AW-1:0] ua, input logic ut,
                       input logic [AW-1:0] utg, input string tag);
      int i;
      logic          e_hit, e_pred;
      logic [AW-1:0] e_next;
      @(negedge clk);
      fetch_addr = fa; upd_valid = uv; upd_addr = ua;
      upd_taken = ut; upd_target = utg;
      #1;
      i = m_find(fa);
      e_hit  = (i >= 0);
      e_pred = e_hit ? m_new[i] : 1'b0;
      e_next = e_pred ? m_tgt[i] : fa + AW'(STEP);
      check(hit == e_hit, {tag, " R2 hit"}, AW'(hit), AW'(e_hit));
      if (e_hit) check(pred_taken == e_pred, {tag, " R3 pred"}, AW'(pred_taken), AW'(e_pred));
      else       check(pred_taken == 1'b0, {tag, " R10 pred"}, AW'(pred_taken), '0);
      check(next_fetch_addr == e_next, {tag, " R4 next"}, next_fetch_addr, e_next);
      @(posedge clk);
      if (uv) m_update();
   endtask

   function automatic logic [AW-1:0] pool(input int k);
      return 32'h0000_1000 + AW'(k) * 32'h40;
   endfunction

   initial begin
      m_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: nothing stored after reset
      step(32'h100, 1'b0, '0, 1'b0, '0, "R1");
      check(hit == 1'b0 && next_fetch_addr == 32'h104, "R1 reset next",
            next_fetch_addr, 32'h104);
      // R8 + R6: same-cycle lookup misses, then the entry appears
      step(pool(0), 1'b1, pool(0), 1'b1, 32'h8000, "R8");
      step(pool(0), 1'b0, '0, 1'b0, '0, "R6");
      check(hit && next_fetch_addr == 32'h8000, "R6 alloc target",
            next_fetch_addr, 32'h8000);
      // R9: ignored update inputs
      step(pool(1), 1'b0, pool(0), 1'b0, 32'hdead, "R9");
      step(pool(0), 1'b0, '0, 1'b0, '0, "R9");
      check(pred_taken && next_fetch_addr == 32'h8000, "R9 unchanged",
            next_fetch_addr, 32'h8000);
      // R5: history shift and target replacement
      step(pool(2), 1'b1, pool(0), 1'b0, 32'h9000, "R5");
      step(pool(0), 1'b1, pool(0), 1'b1, 32'hA000, "R5");
      check(pred_taken == 1'b0 && next_fetch_addr == pool(0) + 4, "R5 not taken",
            next_fetch_addr, pool(0) + 4);
      step(pool(0), 1'b0, '0, 1'b0, '0, "R5");
      check(pred_taken && next_fetch_addr == 32'hA000, "R5 taken again",
            next_fetch_addr, 32'hA000);
      // R7: fill the rest, then evict the first fill
      for (int k = 1; k < NE; k++) step(pool(9), 1'b1, pool(k), 1'b1, 32'h7000 + AW'(k), "R6");
      step(pool(0), 1'b1, pool(NE), 1'b0, 32'h6000, "R7");
      step(pool(0), 1'b0, '0, 1'b0, '0, "R7");
      check(hit == 1'b0, "R7 first evicted", AW'(hit), '0);
      step(pool(1), 1'b1, pool(NE + 1), 1'b1, 32'h6100, "R7");
      step(pool(1), 1'b0, '0, 1'b0, '0, "R7");
      check(hit == 1'b0, "R7 second evicted", AW'(hit), '0);
      // random traffic over a small address pool
      void'($urandom(32'd752));
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] fa, ua;
         fa = pool(int'($urandom_range(0, 9)));
         ua = ($urandom_range(0, 3) == 0) ? fa : pool(int'($urandom_range(0, 9)));
         step(fa, ($urandom_range(0, 2) != 0), ua, 1'($urandom),
              {$urandom} & 32'hFFFF_FFFC, "RND");
      end
      // reset in mid-stream clears everything again
      @(negedge clk);
      rst = 1'b1; upd_valid = 1'b0;
      @(posedge clk);
      m_reset();
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 10; k++) step(pool(k), 1'b0, '0, 1'b0, '0, "R1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule